// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a synchronous memory with two independent ports, A and B. The storage is split into banks, and each bank is a single-port array. On every access a port names a bank and a word inside that bank. Both ports can work at the same time as long as they use different banks. If both ports address the same bank in the same cycle, neither access takes effect. Each port then raises a collision flag and reports no valid read data.

Every port input is captured on the rising clock edge. Writes are masked per 9-bit lane of the 36-bit word. Read data leaves the block on one of two schedules, chosen per port by a mode input: flow-through, one cycle after the capturing edge, or pipelined, one cycle later than that. In this model both ports share one clock. The bank count and the words per bank are parameters; the defaults are kept small for simulation.

Top module: `dpbank_top`

## Requirements
- R1: A word written through either port at a given (bank, word) location is returned by either port when that location is read later. The default geometry is 8 banks (3-bit bank field) of 64 words (6-bit word field), 36 bits per word.
- R2: With mode input 0 (flow-through), the read data and the valid output appear in the cycle that follows the clock edge which captured the read request.
- R3: With mode input 1 (pipelined), the read data and the valid output appear one cycle later than in flow-through mode. Back-to-back reads stream out one per cycle.
- R4: Lane enable bit i controls bits [9i+8:9i] of the word. On a write, a lane whose enable is 1 takes the new data and a lane whose enable is 0 keeps its old contents.
- R5: When both ports are selected and name the same bank in the same captured cycle, each port raises its collision output and its valid output stays 0. The flag appears with that port's read-data timing.
- R6: A write captured in a collision cycle does not change the memory.
- R7: A port is selected only when its active-low enable is 0 and its active-high enable is 1. An unselected port writes nothing, reads nothing and takes no part in a collision.
- R8: When the captured output enable is 0, the valid output stays 0 for that read.
- R9: While the valid output is 0, the read-data output is all zeros.
- R10: The read/write input is 1 for read and 0 for write. A read captured in the cycle after a write to the same location returns the newly written word.
- R11: During reset, every read-data, valid and collision output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Port A enable, active low |
| a_sel | input | 1 | Port A enable, active high |
| a_rnw | input | 1 | Port A: 1 = read, 0 = write |
| a_oe | input | 1 | Port A output enable |
| a_pipe | input | 1 | Port A mode: 1 = pipelined, 0 = flow-through |
| a_bank | input | BA_W | Port A bank address |
| a_word | input | WA_W | Port A word address within the bank |
| a_wdata | input | 36 | Port A write data |
| a_lanes | input | 4 | Port A lane write enables |
| a_rdata | output | 36 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_clash | output | 1 | Port A bank collision flag |
| b_sel_n | input | 1 | Port B enable, active low |
| b_sel | input | 1 | Port B enable, active high |
| b_rnw | input | 1 | Port B: 1 = read, 0 = write |
| b_oe | input | 1 | Port B output enable |
| b_pipe | input | 1 | Port B mode: 1 = pipelined, 0 = flow-through |
| b_bank | input | BA_W | Port B bank address |
| b_word | input | WA_W | Port B word address within the bank |
| b_wdata | input | 36 | Port B write data |
| b_lanes | input | 4 | Port B lane write enables |
| b_rdata | output | 36 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_clash | output | 1 | Port B bank collision flag |

## Verification
The bench first makes a write and a read collide in one bank, then reads the target word back. A design that let the colliding write through would return the new word instead of the old one. A design that arbitrated the collision would show valid data on one port. Writes are also issued with each of the two enables off. A decoder that looks at only one enable would corrupt the stored word or raise a false collision. The bench runs the two ports in different modes at the same time and streams pipelined reads back to back. A design with a stage off by one would deliver data one cycle early or late. A partial-lane write followed at once by a read catches both a wrong lane-to-bit mapping and a missing bypass of the freshly written word.

// File: rtl/dpbank_pkg.sv
package dpbank_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // Replace only the lanes whose enable bit is set.
  function automatic word_t merge_lanes(word_t old_w, word_t new_w, lane_t en);
    word_t r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  // A port is selected only with both enables asserted.
  function automatic logic port_on(logic sel_n, logic sel);
    return !sel_n && sel;
  endfunction
endpackage

// File: rtl/dpbank_inreg.sv
module dpbank_inreg
  import dpbank_pkg::*;
#(
  parameter int BA_W = 3,
  parameter int WA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            sel,
  input  logic            rnw,
  input  logic            oe,
  input  logic            pipe,
  input  logic [BA_W-1:0] bank,
  input  logic [WA_W-1:0] word,
  input  word_t           wdata,
  input  lane_t           lanes,
  output logic            act_q,
  output logic            rnw_q,
  output logic            oe_q,
  output logic            pipe_q,
  output logic [BA_W-1:0] bank_q,
  output logic [WA_W-1:0] word_q,
  output word_t           wdata_q,
  output lane_t           lanes_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rnw_q   <= 1'b1;
      oe_q    <= 1'b0;
      pipe_q  <= 1'b0;
      bank_q  <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
    end else begin
      act_q   <= port_on(sel_n, sel);
      rnw_q   <= rnw;
      oe_q    <= oe;
      pipe_q  <= pipe;
      bank_q  <= bank;
      word_q  <= word;
      wdata_q <= wdata;
      lanes_q <= lanes;
    end
  end
endmodule

// File: rtl/dpbank_bank.sv
module dpbank_bank
  import dpbank_pkg::*;
#(
  parameter int WA_W = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [WA_W-1:0] addr,
  input  word_t           wdata,
  input  lane_t           lanes,
  output word_t           rdata
);
  localparam int DEPTH = 1 << WA_W;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= merge_lanes(mem[addr], wdata, lanes);
  end

  // Read path is combinational from the registered address.
  assign rdata = mem[addr];
endmodule

// File: rtl/dpbank_outstage.sv
module dpbank_outstage
  import dpbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pipe_q,
  input  logic  ft_valid,
  input  word_t ft_data,
  input  logic  ft_clash,
  output logic  rvalid,
  output word_t rdata,
  output logic  clash
);
  logic  p_valid;
  word_t p_data;
  logic  p_clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_data  <= '0;
      p_clash <= 1'b0;
    end else begin
      p_valid <= ft_valid;
      p_data  <= ft_data;
      p_clash <= ft_clash;
    end
  end

  assign rvalid = pipe_q ? p_valid : ft_valid;
  assign rdata  = pipe_q ? p_data  : ft_data;
  assign clash  = pipe_q ? p_clash : ft_clash;
endmodule

// File: rtl/dpbank_top.sv
module dpbank_top
  import dpbank_pkg::*;
#(
  parameter int BA_W = 3,
  parameter int WA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_sel_n,
  input  logic            a_sel,
  input  logic            a_rnw,
  input  logic            a_oe,
  input  logic            a_pipe,
  input  logic [BA_W-1:0] a_bank,
  input  logic [WA_W-1:0] a_word,
  input  logic [35:0]     a_wdata,
  input  logic [3:0]      a_lanes,
  output logic [35:0]     a_rdata,
  output logic            a_rvalid,
  output logic            a_clash,
  input  logic            b_sel_n,
  input  logic            b_sel,
  input  logic            b_rnw,
  input  logic            b_oe,
  input  logic            b_pipe,
  input  logic [BA_W-1:0] b_bank,
  input  logic [WA_W-1:0] b_word,
  input  logic [35:0]     b_wdata,
  input  logic [3:0]      b_lanes,
  output logic [35:0]     b_rdata,
  output logic            b_rvalid,
  output logic            b_clash
);
  localparam int NBANKS = 1 << BA_W;

  logic            a_act_q, a_rnw_q, a_oe_q, a_pipe_q;
  logic [BA_W-1:0] a_bank_q;
  logic [WA_W-1:0] a_word_q;
  word_t           a_wdata_q;
  lane_t           a_lanes_q;
  logic            b_act_q, b_rnw_q, b_oe_q, b_pipe_q;
  logic [BA_W-1:0] b_bank_q;
  logic [WA_W-1:0] b_word_q;
  word_t           b_wdata_q;
  lane_t           b_lanes_q;

  dpbank_inreg #(.BA_W(BA_W), .WA_W(WA_W)) u_in_a (
    .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel), .rnw(a_rnw),
    .oe(a_oe), .pipe(a_pipe), .bank(a_bank), .word(a_word), .wdata(a_wdata),
    .lanes(a_lanes), .act_q(a_act_q), .rnw_q(a_rnw_q), .oe_q(a_oe_q),
    .pipe_q(a_pipe_q), .bank_q(a_bank_q), .word_q(a_word_q),
    .wdata_q(a_wdata_q), .lanes_q(a_lanes_q));

  dpbank_inreg #(.BA_W(BA_W), .WA_W(WA_W)) u_in_b (
    .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel), .rnw(b_rnw),
    .oe(b_oe), .pipe(b_pipe), .bank(b_bank), .word(b_word), .wdata(b_wdata),
    .lanes(b_lanes), .act_q(b_act_q), .rnw_q(b_rnw_q), .oe_q(b_oe_q),
    .pipe_q(b_pipe_q), .bank_q(b_bank_q), .word_q(b_word_q),
    .wdata_q(b_wdata_q), .lanes_q(b_lanes_q));

  // Named internal events, used by the bound checker.
  logic req_clash;
  logic a_wr_go, b_wr_go;
  assign req_clash = a_act_q && b_act_q && (a_bank_q == b_bank_q);
  assign a_wr_go   = a_act_q && !a_rnw_q && !req_clash;
  assign b_wr_go   = b_act_q && !b_rnw_q && !req_clash;

  word_t bank_rd [NBANKS];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic            own_a, own_b, we;
    logic [WA_W-1:0] addr;
    word_t           wdata;
    lane_t           lanes;
    assign own_a = a_act_q && (a_bank_q == BA_W'(g));
    assign own_b = b_act_q && (b_bank_q == BA_W'(g));
    assign we    = (own_a && a_wr_go) || (own_b && b_wr_go);
    assign addr  = own_a ? a_word_q  : b_word_q;
    assign wdata = own_a ? a_wdata_q : b_wdata_q;
    assign lanes = own_a ? a_lanes_q : b_lanes_q;

    dpbank_bank #(.WA_W(WA_W)) u_bank (
      .clk(clk), .we(we), .addr(addr), .wdata(wdata), .lanes(lanes),
      .rdata(bank_rd[g]));
  end

  logic  a_ft_valid, b_ft_valid;
  word_t a_ft_data, b_ft_data;
  assign a_ft_valid = a_act_q && a_rnw_q && a_oe_q && !req_clash;
  assign b_ft_valid = b_act_q && b_rnw_q && b_oe_q && !req_clash;
  assign a_ft_data  = a_ft_valid ? bank_rd[a_bank_q] : '0;
  assign b_ft_data  = b_ft_valid ? bank_rd[b_bank_q] : '0;

  dpbank_outstage u_out_a (
    .clk(clk), .rst_n(rst_n), .pipe_q(a_pipe_q), .ft_valid(a_ft_valid),
    .ft_data(a_ft_data), .ft_clash(a_act_q && req_clash),
    .rvalid(a_rvalid), .rdata(a_rdata), .clash(a_clash));

  dpbank_outstage u_out_b (
    .clk(clk), .rst_n(rst_n), .pipe_q(b_pipe_q), .ft_valid(b_ft_valid),
    .ft_data(b_ft_data), .ft_clash(b_act_q && req_clash),
    .rvalid(b_rvalid), .rdata(b_rdata), .clash(b_clash));
endmodule

// File: rtl/dpbank_chk.sv
module dpbank_chk #(
  parameter int BA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_clash,
  input logic            a_wr_go,
  input logic            b_wr_go,
  input logic            a_act_q,
  input logic            b_act_q,
  input logic [BA_W-1:0] a_bank_q,
  input logic [BA_W-1:0] b_bank_q,
  input logic            a_pipe_q,
  input logic            a_sel_n,
  input logic            a_sel,
  input logic            a_rnw,
  input logic            a_oe,
  input logic            a_rvalid,
  input logic [35:0]     a_rdata,
  input logic            a_clash,
  input logic            b_rvalid,
  input logic [35:0]     b_rdata,
  input logic            b_clash
);
  assert_clash_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_clash |-> !(a_wr_go || b_wr_go));

  assert_one_writer_per_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_go && b_wr_go) |-> (a_bank_q != b_bank_q));

  assert_unselected_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_act_q |-> !a_wr_go) and (!b_act_q |-> !b_wr_go));

  assert_valid_excludes_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rvalid && a_clash) && !(b_rvalid && b_clash));

  assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_rvalid |-> a_rdata == '0) and (!b_rvalid |-> b_rdata == '0));

  assert_ft_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rvalid && !a_pipe_q) |-> $past(a_rnw && a_oe && !a_sel_n && a_sel));

  assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rvalid && a_pipe_q) |-> $past(a_rnw && a_oe && !a_sel_n && a_sel, 2));
endmodule

bind dpbank_top dpbank_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_clash(req_clash), .a_wr_go(a_wr_go),
  .b_wr_go(b_wr_go), .a_act_q(a_act_q), .b_act_q(b_act_q),
  .a_bank_q(a_bank_q), .b_bank_q(b_bank_q), .a_pipe_q(a_pipe_q),
  .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rnw(a_rnw), .a_oe(a_oe),
  .a_rvalid(a_rvalid), .a_rdata(a_rdata), .a_clash(a_clash),
  .b_rvalid(b_rvalid), .b_rdata(b_rdata), .b_clash(b_clash));

// File: tb/tb_dpbank_top.sv
`timescale 1ns/1ps
module tb_dpbank_top;
  import dpbank_pkg::*;
  localparam int BA_W  = 3;
  localparam int WA_W  = 6;
  localparam int NB    = 1 << BA_W;
  localparam int DEPTH = 1 << WA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic a_sel_n, a_sel, a_rnw, a_oe, a_pipe, b_sel_n, b_sel, b_rnw, b_oe, b_pipe;
  logic [BA_W-1:0] a_bank, b_bank;
  logic [WA_W-1:0] a_word, b_word;
  logic [35:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic [3:0]  a_lanes, b_lanes;
  logic a_rvalid, a_clash, b_rvalid, b_clash;

  dpbank_top #(.BA_W(BA_W), .WA_W(WA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rnw(a_rnw), .a_oe(a_oe), .a_pipe(a_pipe),
    .a_bank(a_bank), .a_word(a_word), .a_wdata(a_wdata), .a_lanes(a_lanes),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_clash(a_clash),
    .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rnw(b_rnw), .b_oe(b_oe), .b_pipe(b_pipe),
    .b_bank(b_bank), .b_word(b_word), .b_wdata(b_wdata), .b_lanes(b_lanes),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_clash(b_clash));

  typedef struct packed {
    logic            sel_n, sel, rnw, oe, pipe;
    logic [BA_W-1:0] bank;
    logic [WA_W-1:0] word;
    logic [35:0]     wdata;
    logic [3:0]      lanes;
  } op_t;

  typedef struct {
    int          due;
    logic        valid;
    logic [35:0] data;
    logic        clash;
    int          req;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];
  logic [35:0] ref_mem [NB*DEPTH];
  int cyc = 0;
  int errs = 0;
  int checks = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [35:0] apply_lanes(logic [35:0] o, logic [35:0] n, logic [3:0] l);
    logic [35:0] m;
    m = {{9{l[3]}}, {9{l[2]}}, {9{l[1]}}, {9{l[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic op_t idle(logic p);
    return '{sel_n:1'b1, sel:1'b0, rnw:1'b1, oe:1'b1, pipe:p, bank:'0, word:'0, wdata:'0, lanes:'0};
  endfunction
  function automatic op_t rd(int bk, int wd, logic p);
    return '{sel_n:1'b0, sel:1'b1, rnw:1'b1, oe:1'b1, pipe:p, bank:BA_W'(bk), word:WA_W'(wd), wdata:'0, lanes:'0};
  endfunction
  function automatic op_t wr(int bk, int wd, logic [35:0] d, logic [3:0] l, logic p);
    return '{sel_n:1'b0, sel:1'b1, rnw:1'b0, oe:1'b1, pipe:p, bank:BA_W'(bk), word:WA_W'(wd), wdata:d, lanes:l};
  endfunction

  // Driver: applies one cycle of stimulus to both ports and queues the expected results.
  task automatic step(op_t a, op_t b, int ra, int rb);
    logic on_a, on_b, cl;
    exp_t ea, eb;
    @(negedge clk);
    a_sel_n = a.sel_n; a_sel = a.sel; a_rnw = a.rnw; a_oe = a.oe; a_pipe = a.pipe;
    a_bank = a.bank; a_word = a.word; a_wdata = a.wdata; a_lanes = a.lanes;
    b_sel_n = b.sel_n; b_sel = b.sel; b_rnw = b.rnw; b_oe = b.oe; b_pipe = b.pipe;
    b_bank = b.bank; b_word = b.word; b_wdata = b.wdata; b_lanes = b.lanes;
    on_a = (a.sel_n == 1'b0) && (a.sel == 1'b1);
    on_b = (b.sel_n == 1'b0) && (b.sel == 1'b1);
    cl   = on_a && on_b && (a.bank == b.bank);
    ea.due = cyc + (a.pipe ? 2 : 1);
    ea.valid = on_a && a.rnw && a.oe && !cl;
    ea.data  = ea.valid ? ref_mem[{a.bank, a.word}] : 36'h0;
    ea.clash = on_a && cl;
    ea.req   = ra;
    eb.due = cyc + (b.pipe ? 2 : 1);
    eb.valid = on_b && b.rnw && b.oe && !cl;
    eb.data  = eb.valid ? ref_mem[{b.bank, b.word}] : 36'h0;
    eb.clash = on_b && cl;
    eb.req   = rb;
    qa.push_back(ea);
    qb.push_back(eb);
    if (on_a && !a.rnw && !cl)
      ref_mem[{a.bank, a.word}] = apply_lanes(ref_mem[{a.bank, a.word}], a.wdata, a.lanes);
    if (on_b && !b.rnw && !cl)
      ref_mem[{b.bank, b.word}] = apply_lanes(ref_mem[{b.bank, b.word}], b.wdata, b.lanes);
  endtask

  task automatic compare(string port, exp_t e, logic v, logic [35:0] d, logic c);
    checks++;
    if (v !== e.valid || d !== e.data || c !== e.clash) begin
      errs++;
      $display("FAIL R%0d port %s cycle %0d: valid/data/clash got %b/%h/%b expected %b/%h/%b",
               e.req, port, cyc, v, d, c, e.valid, e.data, e.clash);
    end
  endtask

  // Monitor: pops every item due this cycle and compares it with the outputs.
  always @(negedge clk) begin
    while (qa.size() > 0 && qa[0].due <= cyc) compare("A", qa.pop_front(), a_rvalid, a_rdata, a_clash);
    while (qb.size() > 0 && qb[0].due <= cyc) compare("B", qb.pop_front(), b_rvalid, b_rdata, b_clash);
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 5000);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  localparam logic [35:0] D1 = 36'h1_2345_6789;
  localparam logic [35:0] D2 = 36'hA_BCDE_F012;
  localparam logic [35:0] D3 = 36'h5_5AA5_A55A;
  localparam logic [35:0] D4 = 36'h0_F0F0_F0F0;
  localparam logic [35:0] D5 = 36'hF_FFFF_FFFF;
  localparam logic [35:0] D6 = 36'h3_3333_3333;
  localparam logic [35:0] D7 = 36'hC_0FFE_E123;
  localparam logic [35:0] D8 = 36'h7_7654_3210;
  localparam logic [35:0] D9 = 36'hE_DCBA_9876;

  initial begin
    op_t o;
    {a_sel_n, a_sel, a_rnw, a_oe, a_pipe} = 5'b10110;
    {b_sel_n, b_sel, b_rnw, b_oe, b_pipe} = 5'b10110;
    a_bank = '0; a_word = '0; a_wdata = '0; a_lanes = '0;
    b_bank = '0; b_word = '0; b_wdata = '0; b_lanes = '0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    checks++;
    if ({a_rvalid, a_clash, b_rvalid, b_clash} !== 4'b0 || a_rdata !== 36'h0 || b_rdata !== 36'h0) begin
      errs++;
      $display("FAIL R11 reset outputs: got %b%b%b%b %h %h expected all zero",
               a_rvalid, a_clash, b_rvalid, b_clash, a_rdata, b_rdata);
    end
    rst_n = 1'b1;

    // Flow-through phase
    step(wr(1, 5, D1, 4'hF, 0), wr(2, 7, D2, 4'hF, 0), 1, 1);   // R1 R10 writes on both ports
    step(rd(2, 7, 0), rd(1, 5, 0), 2, 2);                       // R1 R2 cross reads
    step(wr(1, 5, D3, 4'b0101, 0), idle(0), 4, 4);              // R4 partial lanes
    step(rd(1, 5, 0), idle(0), 10, 10);                         // R4 R10 read right after write
    step(wr(3, 1, D4, 4'hF, 0), idle(0), 1, 1);
    step(wr(3, 1, D5, 4'hF, 0), rd(3, 2, 0), 5, 5);             // R5 R6 same-bank collision
    step(rd(3, 1, 0), idle(0), 6, 6);                           // R6 old word must remain
    o = wr(3, 1, D6, 4'hF, 0); o.sel_n = 1'b1;
    step(o, rd(3, 1, 0), 7, 7);                                 // R7 low enable off: no write, no clash
    o = wr(3, 1, D6, 4'hF, 0); o.sel = 1'b0;
    step(o, idle(0), 7, 7);                                     // R7 high enable off
    step(rd(3, 1, 0), idle(0), 7, 7);                           // R7 word unchanged
    o = rd(2, 7, 0); o.oe = 1'b0;
    step(o, rd(1, 5, 0), 8, 8);                                 // R8 R9 output enable off
    step(wr(NB-1, DEPTH-1, D7, 4'hF, 0), wr(0, 0, D8, 4'hF, 0), 1, 1); // R1 corners
    step(rd(0, 0, 0), rd(NB-1, DEPTH-1, 0), 1, 1);              // R1 corners cross read
    step(idle(0), idle(0), 9, 9);
    step(idle(0), idle(0), 9, 9);

    // Port A pipelined, port B flow-through
    step(idle(1), idle(0), 3, 3);
    step(rd(NB-1, DEPTH-1, 1), rd(0, 0, 0), 3, 2);              // R3 vs R2 side by side
    step(rd(1, 5, 1), wr(0, 0, D9, 4'b1000, 0), 3, 4);          // R3 streaming, R4 top lane
    step(rd(2, 7, 1), rd(0, 0, 0), 3, 10);                      // R3, R10
    step(rd(4, 0, 1), wr(4, 3, D1, 4'hF, 0), 5, 5);             // R5 collision in mixed modes
    step(wr(4, 3, D2, 4'hF, 1), idle(0), 1, 1);
    step(idle(1), rd(4, 3, 0), 6, 6);                           // R6 prior clash left no trace
    step(rd(4, 3, 1), idle(0), 3, 3);                           // R3
    step(idle(1), idle(0), 9, 9);
    step(idle(1), idle(0), 9, 9);
    step(idle(1), idle(0), 9, 9);
    repeat (3) @(negedge clk);
    if (qa.size() != 0 || qb.size() != 0) begin
      errs++;
      $display("FAIL R2 queues not drained: got %0d/%0d expected 0/0", qa.size(), qb.size());
    end
    finish_run();
  end
endmodule